// File: doc/BRIEF.md
# Phase-Synchronized PWM Time Base

A single-channel pulse-width generator built around an up-counting time base with two compare channels. Several copies, on one die or on separate boards, can be phase-locked through a sync chain. One instance acts as master. The others see its sync pulse and reload their counters with a programmable phase value, which lets channels be staggered by a chosen fraction of the period.

The period and both compare values are shadowed and only take effect when the counter wraps to zero. The external sync input passes through a qualifier and then a rising-edge detector. The qualifier is either a two-flop synchronizer or a bypass. The edge then waits in a fixed-length event pipeline before it acts on the counter. The pipeline latency is constant, so software can compensate for it in the phase value. The sync output either re-emits a one-clock pulse at counter zero or forwards the detected input event, so instances can be daisy-chained. A freeze control stops the counter and holds the outputs while the period is reprogrammed.

Top module: `phase_sync_pwm`

## Requirements
- R1: While reset is asserted and right after release (compare values 0, sync-out select 0), pwm_a_o, pwm_b_o and sync_out_o are 0.
- R2: With active period P, the counter runs 0,1,…,P then wraps to 0, so rising edges of pwm_a_o are P+1 clocks apart.
- R3: A period write goes to a shadow register. The running period completes with the old value, and the new value governs the period that starts at the next wrap.
- R4: Each output goes high in the clock after the counter is 0 and goes low in the clock after the counter equals its compare value. For a compare value C with 1 ≤ C ≤ P, the output is high for exactly C clocks per period. Compare values are shadowed and load at the wrap.
- R5: A compare value of 0 gives a constant low output (0% duty).
- R6: Qualifier select 0 (synchronous): with phase_en_i=1, the counter holds phase_val_i 6 clocks after the first clock edge that samples sync_in_i high. That edge counts as clock 1. With phase value F (1 ≤ F ≤ P), counter zero therefore occurs in clock 6+(P+1−F), and pwm_a_o rises one clock later. This latency is the same for every sync pulse.
- R7: Qualifier select 1 (asynchronous bypass): the same rules as R6 apply, with a latency of 4 clocks instead of 6.
- R8: With phase_en_i=0, sync events do not change the counter, and the counter-zero timing continues undisturbed.
- R9: Only a rising edge of sync_in_i is an event. Holding the input high, and its falling edge, cause no reload.
- R10: Sync-out select 0 forwards each detected event as a one-clock pulse on sync_out_o. The pulse appears in clock 5 (synchronous) or clock 3 (asynchronous), counted as in R6, whether or not phase_en_i is set.
- R11: Sync-out select 1 drives sync_out_o high for exactly the one clock in which the counter is 0, once per period.
- R12: While freeze_i=1, the counter, pwm_a_o and pwm_b_o hold their values and select 1 emits no sync pulse. A period written during freeze applies from the first wrap after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| prd_wr_i | input | 1 | Period shadow write strobe |
| prd_val_i | input | CNT_W | Period value |
| cmpa_wr_i | input | 1 | Compare A shadow write strobe |
| cmpa_val_i | input | CNT_W | Compare A value |
| cmpb_wr_i | input | 1 | Compare B shadow write strobe |
| cmpb_val_i | input | CNT_W | Compare B value |
| phase_val_i | input | CNT_W | Counter value loaded on a sync event |
| phase_en_i | input | 1 | 1: sync events reload the counter |
| sync_out_sel_i | input | 1 | 0: forward input event, 1: pulse at counter zero |
| freeze_i | input | 1 | Hold counter and outputs |
| qual_async_i | input | 1 | 0: two-flop synchronizer, 1: bypass |
| sync_in_i | input | 1 | External sync, rising-edge active |
| pwm_a_o | output | 1 | PWM output A |
| pwm_b_o | output | 1 | PWM output B |
| sync_out_o | output | 1 | Sync output pulse |

## Verification
Both PWM outputs are registered, so each one moves one clock after the counter reaches zero or its compare value. The zero-select sync output is combinational from the counter and is high during the zero clock itself. After a sync edge, the forwarded pulse is due in clock 5 (or 3 in bypass), counter zero in clock 6+(P+1−F) (or 4+…), and the rise of A one clock after that. The bench drives inputs just after a falling edge, counts rising edges from there, and samples only at falling edges in exactly those clocks. The expected clock numbers are computed from the period and phase values chosen. Shadowed values are checked by measuring whole periods only after enough wraps for the new values to load.

// File: rtl/pwm_sync_pkg.sv
package pwm_sync_pkg;
  typedef enum logic {SYNCO_PASS = 1'b0, SYNCO_ZERO = 1'b1} synco_sel_e;
  typedef enum logic {QUAL_SYNC = 1'b0, QUAL_BYPASS = 1'b1} qual_mode_e;
endpackage

// File: rtl/sync_qualifier.sv
module sync_qualifier #(
  parameter int SYNC_STAGES = 2,
  parameter int EVT_STAGES  = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic bypass_i,
  output logic evt_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [EVT_STAGES-1:0]  evt_q;
  logic qual, prev_q, edge_det;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q[0] <= 1'b0;
        else         sync_q[0] <= pin_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q[i] <= 1'b0;
        else         sync_q[i] <= sync_q[i-1];
    end
  end

  assign qual = bypass_i ? pin_i : sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= qual;

  // rising edge only
  assign edge_det = qual & ~prev_q;

  // fixed event pipeline: latency independent of counter state
  for (genvar j = 0; j < EVT_STAGES; j++) begin : g_evt
    if (j == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) evt_q[0] <= 1'b0;
        else         evt_q[0] <= edge_det;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) evt_q[j] <= 1'b0;
        else         evt_q[j] <= evt_q[j-1];
    end
  end

  assign evt_o = evt_q[EVT_STAGES-1];
endmodule

// File: rtl/pwm_time_base.sv
module pwm_time_base #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          freeze_i,
  input  logic          load_i,
  input  logic [CW-1:0] phase_i,
  input  logic          prd_wr_i,
  input  logic [CW-1:0] prd_val_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] prd_act_o,
  output logic          wrap_o
);
  logic [CW-1:0] cnt_q, prd_sh_q, prd_act_q;
  logic wrap;

  // >= recovers if a phase beyond the period was loaded
  assign wrap = !freeze_i && !load_i && (cnt_q >= prd_act_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      prd_sh_q  <= '0;
      prd_act_q <= '0;
    end else begin
      if (prd_wr_i) prd_sh_q <= prd_val_i;
      if (wrap)     prd_act_q <= prd_sh_q;
      if (!freeze_i) begin
        if (load_i)    cnt_q <= phase_i;
        else if (wrap) cnt_q <= '0;
        else           cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  assign cnt_o     = cnt_q;
  assign prd_act_o = prd_act_q;
  assign wrap_o    = wrap;
endmodule

// File: rtl/pwm_action_ch.sv
module pwm_action_ch #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          freeze_i,
  input  logic          wrap_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          cmp_wr_i,
  input  logic [CW-1:0] cmp_val_i,
  output logic [CW-1:0] cmp_act_o,
  output logic          pwm_o
);
  logic [CW-1:0] cmp_sh_q, cmp_act_q;
  logic pwm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_sh_q  <= '0;
      cmp_act_q <= '0;
      pwm_q     <= 1'b0;
    end else begin
      if (cmp_wr_i) cmp_sh_q <= cmp_val_i;
      if (wrap_i)   cmp_act_q <= cmp_sh_q;
      if (!freeze_i) begin
        // clear wins over set: compare 0 means 0% duty
        if (cnt_i == cmp_act_q) pwm_q <= 1'b0;
        else if (cnt_i == '0)   pwm_q <= 1'b1;
      end
    end
  end

  assign cmp_act_o = cmp_act_q;
  assign pwm_o     = pwm_q;
endmodule

// File: rtl/phase_sync_pwm.sv
module phase_sync_pwm
  import pwm_sync_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int EVT_STAGES  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             prd_wr_i,
  input  logic [CNT_W-1:0] prd_val_i,
  input  logic             cmpa_wr_i,
  input  logic [CNT_W-1:0] cmpa_val_i,
  input  logic             cmpb_wr_i,
  input  logic [CNT_W-1:0] cmpb_val_i,
  input  logic [CNT_W-1:0] phase_val_i,
  input  logic             phase_en_i,
  input  logic             sync_out_sel_i,
  input  logic             freeze_i,
  input  logic             qual_async_i,
  input  logic             sync_in_i,
  output logic             pwm_a_o,
  output logic             pwm_b_o,
  output logic             sync_out_o
);
  localparam int NUM_CH = 2;

  logic             sync_evt, load;
  logic [CNT_W-1:0] cnt, prd_act;
  logic             wrap, cnt_zero;
  logic [NUM_CH-1:0] cmp_wr, pwm;
  logic [CNT_W-1:0] cmp_val [NUM_CH];
  logic [CNT_W-1:0] cmp_act [NUM_CH];
  synco_sel_e       so_sel;
  qual_mode_e       q_mode;

  assign so_sel = synco_sel_e'(sync_out_sel_i);
  assign q_mode = qual_mode_e'(qual_async_i);

  sync_qualifier #(
    .SYNC_STAGES(SYNC_STAGES),
    .EVT_STAGES (EVT_STAGES)
  ) u_qual (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pin_i   (sync_in_i),
    .bypass_i(q_mode == QUAL_BYPASS),
    .evt_o   (sync_evt)
  );

  assign load = sync_evt & phase_en_i;

  pwm_time_base #(.CW(CNT_W)) u_tb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .freeze_i (freeze_i),
    .load_i   (load),
    .phase_i  (phase_val_i),
    .prd_wr_i (prd_wr_i),
    .prd_val_i(prd_val_i),
    .cnt_o    (cnt),
    .prd_act_o(prd_act),
    .wrap_o   (wrap)
  );

  assign cnt_zero   = (cnt == '0);
  assign cmp_wr     = {cmpb_wr_i, cmpa_wr_i};
  assign cmp_val[0] = cmpa_val_i;
  assign cmp_val[1] = cmpb_val_i;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pwm_action_ch #(.CW(CNT_W)) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .freeze_i (freeze_i),
      .wrap_i   (wrap),
      .cnt_i    (cnt),
      .cmp_wr_i (cmp_wr[c]),
      .cmp_val_i(cmp_val[c]),
      .cmp_act_o(cmp_act[c]),
      .pwm_o    (pwm[c])
    );
  end

  assign pwm_a_o    = pwm[0];
  assign pwm_b_o    = pwm[1];
  assign sync_out_o = (so_sel == SYNCO_ZERO) ? (cnt_zero && !freeze_i) : sync_evt;
endmodule

// File: rtl/pwm_sync_checker.sv
module pwm_sync_checker #(
  parameter int CW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          freeze_i,
  input logic          phase_en_i,
  input logic          evt_i,
  input logic [CW-1:0] phase_i,
  input logic [CW-1:0] cnt_i,
  input logic [CW-1:0] prd_act_i,
  input logic [CW-1:0] cmp_a_act_i,
  input logic [CW-1:0] cmp_b_act_i,
  input logic          pwm_a_i,
  input logic          pwm_b_i
);
  p_count_up_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !freeze_i && !(evt_i && phase_en_i) && cnt_i < prd_act_i |=> cnt_i == $past(cnt_i) + CW'(1));

  p_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !freeze_i && !(evt_i && phase_en_i) && cnt_i == prd_act_i |=> cnt_i == '0);

  p_zero_duty_a_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !freeze_i && cmp_a_act_i == '0 && cnt_i == '0 |=> !pwm_a_i);

  p_zero_duty_b_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !freeze_i && cmp_b_act_i == '0 && cnt_i == '0 |=> !pwm_b_i);

  p_phase_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !freeze_i && evt_i && phase_en_i |=> cnt_i == $past(phase_i));

  p_ignore_sync_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !freeze_i && evt_i && !phase_en_i && cnt_i < prd_act_i |=> cnt_i == $past(cnt_i) + CW'(1));

  p_single_event_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> !evt_i);

  p_freeze_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze_i && $past(freeze_i) |-> $stable(cnt_i) && $stable(pwm_a_i) && $stable(pwm_b_i));
endmodule

bind phase_sync_pwm pwm_sync_checker #(.CW(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .freeze_i   (freeze_i),
  .phase_en_i (phase_en_i),
  .evt_i      (sync_evt),
  .phase_i    (phase_val_i),
  .cnt_i      (cnt),
  .prd_act_i  (prd_act),
  .cmp_a_act_i(cmp_act[0]),
  .cmp_b_act_i(cmp_act[1]),
  .pwm_a_i    (pwm_a_o),
  .pwm_b_i    (pwm_b_o)
);

// File: tb/phase_sync_pwm_tb.sv
module phase_sync_pwm_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 16;
  localparam int LAT_SYNC = 6;
  localparam int LAT_BYP  = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic prd_wr = 0, cmpa_wr = 0, cmpb_wr = 0;
  logic [CW-1:0] prd_val = '0, cmpa_val = '0, cmpb_val = '0, phase_val = '0;
  logic phase_en = 0, so_sel = 0, freeze = 0, qual_byp = 0, sync_in = 0;
  logic pwm_a, pwm_b, sync_o;

  int cyc = 0;
  int n_chk = 0, n_err = 0;
  int cur_p = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  phase_sync_pwm #(.CNT_W(CW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .prd_wr_i(prd_wr), .prd_val_i(prd_val),
    .cmpa_wr_i(cmpa_wr), .cmpa_val_i(cmpa_val),
    .cmpb_wr_i(cmpb_wr), .cmpb_val_i(cmpb_val),
    .phase_val_i(phase_val), .phase_en_i(phase_en),
    .sync_out_sel_i(so_sel), .freeze_i(freeze),
    .qual_async_i(qual_byp), .sync_in_i(sync_in),
    .pwm_a_o(pwm_a), .pwm_b_o(pwm_b), .sync_out_o(sync_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_prd(input int v);
    @(negedge clk); prd_val = CW'(v); prd_wr = 1;
    @(negedge clk); prd_wr = 0;
  endtask

  task automatic setup(input int p, input int ca, input int cb);
    @(negedge clk);
    prd_val = CW'(p); cmpa_val = CW'(ca); cmpb_val = CW'(cb);
    prd_wr = 1; cmpa_wr = 1; cmpb_wr = 1;
    @(negedge clk);
    prd_wr = 0; cmpa_wr = 0; cmpb_wr = 0;
    tick(cur_p + p + 8);
    cur_p = p;
  endtask

  task automatic next_rise_a(output int t);
    logic prv;
    prv = pwm_a;
    while (1) begin
      @(negedge clk);
      if (!prv && pwm_a) begin t = cyc; break; end
      prv = pwm_a;
    end
  endtask

  task automatic next_sync_pulse(output int t);
    logic prv;
    prv = sync_o;
    while (1) begin
      @(negedge clk);
      if (!prv && sync_o) begin t = cyc; break; end
      prv = sync_o;
    end
  endtask

  // counter zero and rise of A after a sync edge; compare A = P so A is low just before zero
  task automatic sync_latency(input int p, input int ph, input bit byp, input string req);
    int lat, d;
    phase_val = CW'(ph); phase_en = 1; so_sel = 1; qual_byp = byp;
    setup(p, p, 0);
    tick($urandom_range(p, 0));
    lat = byp ? LAT_BYP : LAT_SYNC;
    d = (p + 1 - ph) % (p + 1);
    sync_in = 1;
    for (int n = 1; n <= lat + d + 1; n++) begin
      @(negedge clk);
      if (n == 3) sync_in = 0;
      if (n == lat + d) begin
        chk({req, " zero after sync"}, int'(sync_o), 1);
        if (ph != 0) chk({req, " A low before rise"}, int'(pwm_a), 0);
      end
      if (n == lat + d + 1 && ph != 0) chk({req, " A rise after sync"}, int'(pwm_a), 1);
    end
    tick(8);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin : main
    int t0, t1, t2, t3, ha, hb, p, ca, cb, cnt_p, bad, tz, target;
    void'($urandom(32'd2024));

    // R1 reset state
    tick(3);
    chk("R1 pwm_a in reset", int'(pwm_a), 0);
    chk("R1 pwm_b in reset", int'(pwm_b), 0);
    chk("R1 sync_o in reset", int'(sync_o), 0);
    rst_n = 1;
    tick(3);
    chk("R1 pwm_a after reset", int'(pwm_a), 0);
    chk("R1 sync_o after reset", int'(sync_o), 0);

    // R2 R4 R5 random period and duty
    for (int it = 0; it < 8; it++) begin
      p  = $urandom_range(40, 8);
      ca = (it == 1) ? 0 : $urandom_range(p, 1);
      cb = (it == 0) ? 0 : $urandom_range(p, 0);
      setup(p, ca, cb);
      ha = 0; hb = 0;
      for (int k = 0; k < p + 1; k++) begin
        @(negedge clk);
        ha += int'(pwm_a); hb += int'(pwm_b);
      end
      chk((ca == 0) ? "R5 A high clocks" : "R4 A high clocks", ha, ca);
      chk((cb == 0) ? "R5 B high clocks" : "R4 B high clocks", hb, cb);
      if (ca != 0) begin
        next_rise_a(t1); next_rise_a(t2);
        chk("R2 A period", t2 - t1, p + 1);
      end
    end

    // R3 shadowed period
    setup(20, 1, 0);
    next_rise_a(t1);
    tick(2);
    wr_prd(35);
    next_rise_a(t2); next_rise_a(t3);
    chk("R3 old period completes", t2 - t1, 21);
    chk("R3 new period after wrap", t3 - t2, 36);
    cur_p = 35;

    // R11 zero pulse
    so_sel = 1;
    setup(17, 4, 9);
    next_sync_pulse(t1);
    @(negedge clk);
    chk("R11 pulse width", int'(sync_o), 0);
    next_sync_pulse(t2);
    chk("R11 pulse spacing", t2 - t1, 18);

    // R6 synchronous qualification, R7 bypass
    sync_latency(20, 7, 0, "R6");
    sync_latency(20, 0, 0, "R6");
    sync_latency(20, 20, 0, "R6");
    for (int it = 0; it < 5; it++) begin
      p = $urandom_range(40, 10);
      sync_latency(p, $urandom_range(p, 1), 0, "R6");
    end
    sync_latency(25, 3, 1, "R7");
    for (int it = 0; it < 4; it++) begin
      p = $urandom_range(40, 10);
      sync_latency(p, $urandom_range(p, 1), 1, "R7");
    end
    qual_byp = 0;

    // R8 phase disabled: zero timing undisturbed
    phase_en = 0; phase_val = CW'(10); so_sel = 1;
    setup(30, 5, 0);
    next_sync_pulse(t0);
    tick(4);
    sync_in = 1; tick(3); sync_in = 0;
    cnt_p = 0; bad = 0;
    for (int k = 0; k < 4 * 31; k++) begin
      @(negedge clk);
      if (sync_o) begin
        cnt_p++;
        if ((cyc - t0) % 31 != 0) bad++;
      end
    end
    chk("R8 zero pulses off grid", bad, 0);
    chk("R8 zero pulse count", cnt_p, 4);

    // R9 level and falling edge do not reload
    phase_en = 1; phase_val = CW'(7); so_sel = 1;
    setup(20, 20, 0);
    t0 = cyc;
    tz = t0 + LAT_SYNC + 14;
    target = tz + 2 * 21 + 3;
    sync_in = 1;
    while (cyc < target) begin
      @(negedge clk);
      if (cyc == tz) chk("R9 initial reload", int'(sync_o), 1);
    end
    sync_in = 0;
    cnt_p = 0; bad = 0;
    for (int k = 0; k < 3 * 21; k++) begin
      @(negedge clk);
      if (sync_o) begin
        cnt_p++;
        if ((cyc - tz) % 21 != 0) bad++;
      end
    end
    chk("R9 no reload on level or fall", bad, 0);
    chk("R9 zero pulse count", cnt_p, 3);

    // R10 pass-through, both qualifier modes
    phase_en = 0; so_sel = 0;
    for (int m = 0; m < 2; m++) begin
      int lat;
      qual_byp = m[0];
      lat = (m == 1) ? LAT_BYP : LAT_SYNC;
      tick(10);
      sync_in = 1;
      for (int n = 1; n <= lat + 1; n++) begin
        @(negedge clk);
        if (n == 3) sync_in = 0;
        chk("R10 forwarded pulse", int'(sync_o), int'(n == lat - 1));
      end
    end
    qual_byp = 0;

    // R12 freeze holds outputs, period change while frozen
    so_sel = 1;
    setup(30, 10, 20);
    tick($urandom_range(30, 0));
    freeze = 1;
    @(negedge clk);
    t0 = int'(pwm_a); t1 = int'(pwm_b);
    bad = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (int'(pwm_a) != t0 || int'(pwm_b) != t1 || sync_o) bad++;
    end
    chk("R12 frozen outputs stable", bad, 0);
    wr_prd(50);
    freeze = 0;
    next_rise_a(t1); next_rise_a(t2); next_rise_a(t3);
    chk("R12 period after release", t3 - t2, 51);
    cur_p = 50;

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule